// File: doc/BRIEF.md
# Banked Integer Register File with Privileged Shadow Bank

This block is a 32-entry integer register file with two combinational read ports and one write port. Writes land on the rising clock edge. Index 31 is a constant zero. Eight architectural indices (8 through 14, and 25) each have a partner register in a shadow bank. While the core runs in privileged firmware mode, reads and writes to those indices use the shadow partners. Every other index uses the same storage in both modes.

Entering or leaving privileged mode is requested with a one-cycle strobe plus a direction bit. The swap does not copy any data. A single bank-select bit steers accesses to the aliased indices, so the normal values and the shadow values are both kept across any number of transitions. If an entry request arrives while privileged mode is already active, nothing changes. An exit request clears the select bit, and the aliased indices then map back to their normal registers.

Top module: `banked_gpr_file`

## Requirements
- R1: After reset, every index reads zero on both ports and `privActive` is 0.
- R2: Index 31 reads zero in both modes. A write to index 31 changes nothing in either bank.
- R3: Indices 0–7, 15–24 and 26–30 use one storage location that is shared by both modes. A write in either mode is visible in the other.
- R4: While `privActive` is 1, indices 8–14 map to shadow slots 0–6 and index 25 maps to slot 7. Writes to these indices in privileged mode leave the normal registers unchanged.
- R5: A strobe with `modeEnter`=1 sets `privActive` on the next edge. If `privActive` is already 1, the strobe changes neither the mode nor any value that can be read.
- R6: A strobe with `modeEnter`=0 clears `privActive` on the next edge. The normal values of the aliased indices become visible again. The shadow values are kept and reappear on the next entry.
- R7: A write takes effect at the next rising edge. A read of the index being written in the same cycle returns the old value.
- R8: In a cycle that carries a mode strobe, reads and the write use the bank that is active before that edge.
- R9: The two read ports are independent. Each port returns the value of its own address in the current bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write index |
| wrData | input | 64 | Write data |
| rdAddrA | input | 5 | Read port A index |
| rdAddrB | input | 5 | Read port B index |
| modeStrobe | input | 1 | One-cycle mode change request |
| modeEnter | input | 1 | 1 = enter privileged mode, 0 = leave it (used only with `modeStrobe`) |
| rdDataA | output | 64 | Read port A data |
| rdDataB | output | 64 | Read port B data |
| privActive | output | 1 | 1 while privileged mode and the shadow bank are active |

## Verification
Directed sequences come first. The bench writes distinct values to an aliased index in each mode, then enters, exits and re-enters to show that neither value set is lost. It repeats an entry request while already privileged, which separates a bank-select design from one that swaps again on every request. It also writes index 31 in both modes, and reads an index in the same cycle it is written, which exposes a write-through bypass. A seeded random stream then mixes writes, two-port reads and mode strobes across all 32 indices. A reference model separates errors in the alias mapping (slot 7 against index 25) from errors in the shared indices and from leaks between the banks.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int REG_COUNT    = 32;
  localparam int ADDR_W       = $clog2(REG_COUNT);
  localparam int SHADOW_COUNT = 8;
  localparam int SLOT_W       = $clog2(SHADOW_COUNT);
  localparam logic [ADDR_W-1:0] ZERO_IDX = ADDR_W'(REG_COUNT - 1);
  localparam logic [ADDR_W-1:0] ALIAS_LO = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ALIAS_HI = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ALIAS_EXTRA = ADDR_W'(25);

  typedef struct packed {
    logic              wrMain;
    logic              wrShadow;
    logic [SLOT_W-1:0] wrSlot;
    logic              bankSel;
  } brfStrobes_t;

  function automatic logic isAliased(input logic [ADDR_W-1:0] idx);
    return ((idx >= ALIAS_LO) && (idx <= ALIAS_HI)) || (idx == ALIAS_EXTRA);
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(input logic [ADDR_W-1:0] idx);
    logic [ADDR_W-1:0] off;
    off = idx - ALIAS_LO;
    return (idx == ALIAS_EXTRA) ? SLOT_W'(SHADOW_COUNT - 1) : off[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              modeStrobe,
  input  logic              modeEnter,
  output brfStrobes_t       strobes,
  output logic              privActive
);
  logic bankSel;
  logic aliasHit;

  always_ff @(posedge clk) begin
    if (!rstN)           bankSel <= 1'b0;
    else if (modeStrobe) bankSel <= modeEnter;
  end

  always_comb begin
    aliasHit         = isAliased(wrAddr);
    strobes.bankSel  = bankSel;
    strobes.wrSlot   = slotOf(wrAddr);
    strobes.wrShadow = wrEn && bankSel && aliasHit;
    strobes.wrMain   = wrEn && (wrAddr != ZERO_IDX) && !(bankSel && aliasHit);
  end

  assign privActive = bankSel;

  p_enter_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeStrobe && modeEnter) |=> privActive);
  p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeStrobe && !modeEnter) |=> !privActive);
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !modeStrobe |=> $stable(privActive));
  p_zero_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddr == ZERO_IDX) |-> !strobes.wrMain && !strobes.wrShadow);
endmodule

// File: rtl/brf_datapath.sv
module brf_datapath
  import brf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_RD  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  brfStrobes_t                  strobes,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mainRegs   [REG_COUNT];
  logic [DATA_W-1:0] shadowRegs [SHADOW_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) mainRegs[i] <= '0;
    end else if (strobes.wrMain) begin
      mainRegs[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SHADOW_COUNT; i++) shadowRegs[i] <= '0;
    end else if (strobes.wrShadow) begin
      shadowRegs[strobes.wrSlot] <= wrData;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    always_comb begin
      if (rdAddr[p] == ZERO_IDX)
        rdData[p] = '0;
      else if (strobes.bankSel && isAliased(rdAddr[p]))
        rdData[p] = shadowRegs[slotOf(rdAddr[p])];
      else
        rdData[p] = mainRegs[rdAddr[p]];
    end

    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr[p] == ZERO_IDX) |-> (rdData[p] == '0));
  end

  p_single_bank_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMain, strobes.wrShadow}));
  p_main_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMain |=> (mainRegs[$past(wrAddr)] == $past(wrData)));
  p_shadow_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrShadow |=> (shadowRegs[$past(strobes.wrSlot)] == $past(wrData)));
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import brf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              modeStrobe,
  input  logic              modeEnter,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              privActive
);
  localparam int NUM_RD = 2;

  brfStrobes_t                    strobes;
  logic [NUM_RD-1:0][ADDR_W-1:0]  rdAddrVec;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdDataVec;

  assign rdAddrVec = {rdAddrB, rdAddrA};
  assign rdDataA   = rdDataVec[0];
  assign rdDataB   = rdDataVec[1];

  brf_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeStrobe(modeStrobe), .modeEnter(modeEnter),
    .strobes(strobes), .privActive(privActive)
  );

  brf_datapath #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddrVec), .rdData(rdDataVec)
  );
endmodule

// File: tb/banked_gpr_file_tb_top.sv
`timescale 1ns/1ps
module banked_gpr_file_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [63:0] wrData;
  logic [4:0]  rdAddrA, rdAddrB;
  logic        modeStrobe, modeEnter;
  logic [63:0] rdDataA, rdDataB;
  logic        privActive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mainM [32];
  logic [63:0] shadM [8];
  logic        privM;

  always #4 clk = ~clk;

  banked_gpr_file dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .modeStrobe(modeStrobe),
    .modeEnter(modeEnter), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .privActive(privActive)
  );

  function automatic bit aliasM(input logic [4:0] a);
    return (a >= 5'd8 && a <= 5'd14) || a == 5'd25;
  endfunction

  function automatic int slotM(input logic [4:0] a);
    return (a == 5'd25) ? 7 : int'(a) - 8;
  endfunction

  function automatic logic [63:0] expRead(input logic [4:0] a);
    if (a == 5'd31) return 64'd0;
    if (privM && aliasM(a)) return shadM[slotM(a)];
    return mainM[a];
  endfunction

  function automatic string tagOf(input logic [4:0] a);
    if (a == 5'd31) return "R2";
    if (aliasM(a)) return "R4";
    return "R3";
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [4:0] wa, input logic [63:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb,
                      input bit ms, input bit me, input string tag);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdAddrA = ra; rdAddrB = rb; modeStrobe = ms; modeEnter = me;
    #1;
    check(rdDataA, expRead(ra), tag);
    check(rdDataB, expRead(rb), "R9");
    check({63'd0, privActive}, {63'd0, privM}, "R5/R6 mode");
    @(posedge clk);
    if (we && wa != 5'd31) begin
      if (privM && aliasM(wa)) shadM[slotM(wa)] = wd;
      else mainM[wa] = wd;
    end
    if (ms) privM = me;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mainM[i] = '0;
    for (int i = 0; i < 8; i++) shadM[i] = '0;
    privM = 1'b0;
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0; rdAddrA = 0; rdAddrB = 0;
    modeStrobe = 0; modeEnter = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state on both ports
    for (int i = 0; i < 32; i++)
      step(0, 0, 0, 5'(i), 5'(31 - i), 0, 0, "R1");

    // R7: same-cycle write/read returns old value, next cycle new value
    step(1, 5'd8, 64'hAAAA_0008, 5'd8, 5'd3, 0, 0, "R7");
    step(1, 5'd25, 64'hAAAA_0025, 5'd8, 5'd25, 0, 0, "R7");
    step(1, 5'd3, 64'hCCCC_0003, 5'd25, 5'd3, 0, 0, "R7");
    // R8: write in the entry cycle goes to the normal bank
    step(1, 5'd14, 64'hAAAA_0014, 5'd14, 5'd8, 1, 1, "R8");
    // R4: shadow view after entry, normal values hidden
    step(0, 0, 0, 5'd8, 5'd25, 0, 0, "R4");
    step(1, 5'd8, 64'hBBBB_0008, 5'd14, 5'd3, 0, 0, "R4");
    step(1, 5'd25, 64'hBBBB_0025, 5'd8, 5'd25, 0, 0, "R4");
    step(1, 5'd3, 64'hDDDD_0003, 5'd25, 5'd3, 0, 0, "R3");
    // R5: entry while already privileged changes nothing
    step(0, 0, 0, 5'd8, 5'd25, 1, 1, "R5");
    step(0, 0, 0, 5'd8, 5'd25, 0, 0, "R5");
    // R2: write to 31 ignored in privileged mode
    step(1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 5'd8, 0, 0, "R2");
    // R8: write in the exit cycle still goes to shadow
    step(1, 5'd9, 64'hBBBB_0009, 5'd31, 5'd9, 1, 0, "R8");
    // R6: normal values back
    step(0, 0, 0, 5'd8, 5'd25, 0, 0, "R6");
    step(1, 5'd31, 64'h1234, 5'd9, 5'd3, 0, 0, "R2");
    step(0, 0, 0, 5'd31, 5'd14, 1, 1, "R2");
    // R6: shadow values retained on re-entry
    step(0, 0, 0, 5'd8, 5'd9, 0, 0, "R6");
    step(0, 0, 0, 5'd25, 5'd3, 1, 0, "R6");
    step(0, 0, 0, 5'd8, 5'd25, 0, 0, "R6");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ra;
      logic [4:0] rb;
      logic [4:0] wa;
      logic [63:0] wd;
      bit we, ms, me;
      ra = 5'($urandom_range(0, 31));
      rb = 5'($urandom_range(0, 31));
      wa = ($urandom_range(0, 3) == 0) ? 5'd25 : 5'($urandom_range(0, 31));
      wd = {$urandom, $urandom};
      we = ($urandom_range(0, 3) != 0);
      ms = ($urandom_range(0, 7) == 0);
      me = $urandom_range(0, 1) == 1;
      step(we, wa, wd, ra, rb, ms, me, tagOf(ra));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule